// File: doc/BRIEF.md
# Status-Qualified Halt Clock Stopper

This block sits next to a clock divider and decides when the system clocks may run. It watches the three processor status lines, sampled on the oscillator tick. When those lines show the idle code and then move to the halt code, it shuts the clocks down. The peripheral clock enable drops first, so that clock freezes at whatever level it holds. The CPU clock enable and the 50% duty clock enable follow after two more CPU clock cycles. The divider reports each of those cycles, at its high phase, on a tick input. Because the delay is counted in these ticks, the shutdown lands in the high state at any division ratio, slow or fast.

A mode select chooses what a completed stop does. With the mode input low, the oscillator-run flag is cleared as well. With it high, the oscillator keeps running and only the derived clocks are gated. A rising edge on the start input always brings the clocks back. After a start or a reset, the detector is disarmed until it sees a fresh idle code. A stop line left low therefore cannot stop the clocks again. With the two lower status bits tied high, the top status line works on its own as an active-low stop command.

Top module: `hcs_top`

## Requirements
- R1: When the synchronised status changes from 111 directly to 011, the block begins a stop. With status[1:0] held at 11, a falling edge on status[2] alone does this.
- R2: A 011 code whose preceding synchronised code is anything other than 111 leaves all outputs high. This covers 011 present since reset and 011 reached from 001 or 110.
- R3: Take the oscillator edge at which the status input changes as edge 0. pclk_en_o goes low at the third edge (two synchroniser stages plus one register). cpu_clk_en_o and duty_clk_en_o stay high at that edge.
- R4: cpu_clk_en_o and duty_clk_en_o fall together, at the edge that samples the second cyc_tick_i pulse after the stop began. They are always equal.
- R5: The spacing of cyc_tick_i pulses has no effect on when the stop completes. Only their count matters, so slow and fast clocking behave alike.
- R6: When a stop has completed, osc_run_o is 0 if mode_gate_i is 0 and 1 if mode_gate_i is 1. osc_run_o is 1 whenever mode_gate_i is 1.
- R7: A rising edge on start_i sets all enables high by the third oscillator edge. This holds even while status stays at 011 and even in the middle of a stop.
- R8: After a start, a status held at 011 does not stop the clocks again. A new 111 followed by 011 stops them again.
- R9: After reset, all four outputs are 1 and the detector is disarmed.
- R10: While a stop is in progress or has completed, further status codes (including another 111 then 011) change no output until a start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_osc | input | 1 | Oscillator tick; all logic runs on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| stat_i | input | 3 | Processor status lines; bit 2 doubles as an active-low stop line |
| mode_gate_i | input | 1 | 0: a completed stop also stops the oscillator; 1: gate the clocks only |
| start_i | input | 1 | Start command; acts on its rising edge |
| cyc_tick_i | input | 1 | One-cycle pulse per CPU clock period, at its high phase, from the divider |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| duty_clk_en_o | output | 1 | 50% duty clock enable |
| pclk_en_o | output | 1 | Peripheral clock enable |
| osc_run_o | output | 1 | Oscillator-run flag |

## Verification
The bench targets bogus halt codes. These are a 011 present straight out of reset, a 011 reached through a 001 glitch, and a 011 after 110. A detector that did not insist on a 111 predecessor would stop the clocks on any of them. It also holds the stop line low across a start and pulses ticks: a design that failed to disarm on start would stop again at once. Ticks are counted one at a time, with both tight and very wide spacing. A design with an off-by-one drain count, or one that timed the drain in oscillator cycles, would drop the CPU enable at the wrong tick. A start in the middle of a drain, and halt codes after the clocks have stopped, probe start priority and whether the halted state is truly frozen.

// File: rtl/hcs_pkg.sv
package hcs_pkg;
  localparam int STAT_W = 3;
  localparam logic [STAT_W-1:0] CODE_IDLE = 3'b111;
  localparam logic [STAT_W-1:0] CODE_HALT = 3'b011;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_DRAIN = 2'd1,
    ST_HALT  = 2'd2
  } stop_state_t;

  function automatic logic is_halt_pair(input logic [STAT_W-1:0] prev_code,
                                        input logic [STAT_W-1:0] cur_code);
    return (prev_code == CODE_IDLE) && (cur_code == CODE_HALT);
  endfunction

  function automatic logic drain_done(input int unsigned count, input int unsigned limit);
    return (count + 1) >= limit;
  endfunction
endpackage

// File: rtl/hcs_sync.sv
module hcs_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe[0] <= '0;
          else        pipe[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe[i] <= '0;
          else        pipe[i] <= pipe[i-1];
        end
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/hcs_halt_detect.sv
module hcs_halt_detect
  import hcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] stat_sy,
  input  logic              disarm,
  output logic              halt_det,
  output logic              idle_seen
);
  logic [STAT_W-1:0] prev_code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      prev_code <= '0;
    else if (disarm) prev_code <= '0;
    else             prev_code <= stat_sy;
  end

  assign idle_seen = (prev_code == CODE_IDLE);
  assign halt_det  = is_halt_pair(prev_code, stat_sy);
endmodule

// File: rtl/hcs_stop_seq.sv
module hcs_stop_seq
  import hcs_pkg::*;
#(
  parameter int DRAIN_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic halt_det,
  input  logic start_pulse,
  input  logic cyc_tick,
  input  logic mode_gate,
  output logic cpu_en,
  output logic duty_en,
  output logic pclk_en,
  output logic osc_run,
  output logic in_drain
);
  localparam int CNT_W = $clog2(DRAIN_CYCLES + 1);

  stop_state_t      state;
  logic [CNT_W-1:0] drain_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_RUN;
      drain_cnt <= '0;
    end else if (start_pulse) begin
      state     <= ST_RUN;
      drain_cnt <= '0;
    end else begin
      unique case (state)
        ST_RUN: begin
          if (halt_det) begin
            state     <= ST_DRAIN;
            drain_cnt <= '0;
          end
        end
        ST_DRAIN: begin
          if (cyc_tick) begin
            if (drain_done(int'(drain_cnt), DRAIN_CYCLES)) state <= ST_HALT;
            else drain_cnt <= drain_cnt + 1'b1;
          end
        end
        ST_HALT: state <= ST_HALT;
        default: state <= ST_RUN;
      endcase
    end
  end

  assign cpu_en   = (state != ST_HALT);
  assign duty_en  = (state != ST_HALT);
  assign pclk_en  = (state == ST_RUN);
  assign in_drain = (state == ST_DRAIN);
  assign osc_run  = !((state == ST_HALT) && !mode_gate);
endmodule

// File: rtl/hcs_top.sv
module hcs_top
  import hcs_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int DRAIN_CYCLES = 2
) (
  input  logic       clk_osc,
  input  logic       rst_n,
  input  logic [2:0] stat_i,
  input  logic       mode_gate_i,
  input  logic       start_i,
  input  logic       cyc_tick_i,
  output logic       cpu_clk_en_o,
  output logic       duty_clk_en_o,
  output logic       pclk_en_o,
  output logic       osc_run_o
);
  logic [STAT_W:0]   sync_in, sync_out;
  logic [STAT_W-1:0] stat_sy;
  logic              start_sy, start_prev;
  logic              start_pulse;
  logic              halt_det;
  logic              idle_seen;
  logic              in_drain;

  assign sync_in = {start_i, stat_i};

  hcs_sync #(.W(STAT_W + 1), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk_osc), .rst_n(rst_n), .d(sync_in), .q(sync_out)
  );

  assign stat_sy  = sync_out[STAT_W-1:0];
  assign start_sy = sync_out[STAT_W];

  always_ff @(posedge clk_osc or negedge rst_n) begin
    if (!rst_n) start_prev <= 1'b0;
    else        start_prev <= start_sy;
  end
  assign start_pulse = start_sy && !start_prev;

  hcs_halt_detect u_det (
    .clk(clk_osc), .rst_n(rst_n), .stat_sy(stat_sy), .disarm(start_pulse),
    .halt_det(halt_det), .idle_seen(idle_seen)
  );

  hcs_stop_seq #(.DRAIN_CYCLES(DRAIN_CYCLES)) u_seq (
    .clk(clk_osc), .rst_n(rst_n), .halt_det(halt_det), .start_pulse(start_pulse),
    .cyc_tick(cyc_tick_i), .mode_gate(mode_gate_i),
    .cpu_en(cpu_clk_en_o), .duty_en(duty_clk_en_o), .pclk_en(pclk_en_o),
    .osc_run(osc_run_o), .in_drain(in_drain)
  );
endmodule

// File: rtl/hcs_top_chk.sv
module hcs_top_chk (
  input logic clk,
  input logic rst_n,
  input logic halt_det,
  input logic idle_seen,
  input logic start_pulse,
  input logic in_drain,
  input logic cyc_tick,
  input logic mode_gate,
  input logic cpu_en,
  input logic duty_en,
  input logic pclk_en,
  input logic osc_run
);
  // R3: the peripheral enable only falls after a decoded halt
  p_pclk_falls_on_decode_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pclk_en) |-> $past(halt_det));

  // R1: a decoded halt implies the detector had seen the idle code
  p_decode_needs_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    halt_det |-> idle_seen);

  // R4: the CPU and duty enables never differ
  p_duty_follows_cpu_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_en == duty_en);

  // R4: the CPU enable falls only on a tick, from the drain phase
  p_cpu_fall_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_en) |-> ($past(cyc_tick) && $past(in_drain) && !pclk_en));

  // R6: gate mode never stops the oscillator
  p_gate_mode_keeps_osc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mode_gate |-> osc_run);

  // R7: start brings every enable back on the next edge
  p_start_resumes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> (cpu_en && duty_en && pclk_en));

  // R8: clocks come back only through a start
  p_restart_needs_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pclk_en) |-> $past(start_pulse));
endmodule

bind hcs_top hcs_top_chk u_chk (
  .clk(clk_osc), .rst_n(rst_n), .halt_det(halt_det), .idle_seen(idle_seen),
  .start_pulse(start_pulse), .in_drain(in_drain), .cyc_tick(cyc_tick_i),
  .mode_gate(mode_gate_i), .cpu_en(cpu_clk_en_o), .duty_en(duty_clk_en_o),
  .pclk_en(pclk_en_o), .osc_run(osc_run_o)
);

// File: tb/hcs_top_test.sv
`timescale 1ns/1ps
module hcs_top_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] stat = 3'b011;
  logic       mode_gate = 1'b0;
  logic       start = 1'b0;
  logic       tick = 1'b0;
  logic       cpu_en, duty_en, pclk_en, osc_run;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    string      tag;
    logic [3:0] exp;
  } item_t;
  item_t sb[$];

  always #4 clk = ~clk;

  hcs_top uut (
    .clk_osc(clk), .rst_n(rst_n), .stat_i(stat), .mode_gate_i(mode_gate),
    .start_i(start), .cyc_tick_i(tick), .cpu_clk_en_o(cpu_en),
    .duty_clk_en_o(duty_en), .pclk_en_o(pclk_en), .osc_run_o(osc_run)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // expected {cpu, duty, pclk, osc} after the next rising edge
  task automatic expect_out(input string tag, input logic [3:0] e);
    @(posedge clk);
    #1;
    sb.push_back('{tag: tag, exp: e});
  endtask

  task automatic tick_pulse();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic start_pulse();
    @(negedge clk) start = 1'b1;
    step(6);
    start = 1'b0;
    step(4);
  endtask

  task automatic begin_stop();
    @(negedge clk) stat = 3'b111;
    step(6);
    stat = 3'b011;
    step(6);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      while (sb.size() > 0) begin
        item_t it;
        logic [3:0] act;
        it  = sb.pop_front();
        act = {cpu_en, duty_en, pclk_en, osc_run};
        n_cmp++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s: got %b expected %b", it.tag, act, it.exp);
        end
      end
    end
  end

  // watchdog
  initial begin
    #(8 * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    step(4);
    rst_n = 1'b1;
    expect_out("R9 reset state", 4'b1111);
    step(8);
    expect_out("R2 011 since reset", 4'b1111);

    // R1/R3: 111 then falling status[2]
    @(negedge clk) stat = 3'b111;
    step(6);
    stat = 3'b011;
    expect_out("R3 edge1", 4'b1111);
    expect_out("R3 edge2", 4'b1111);
    expect_out("R1 R3 edge3 pclk off", 4'b1101);
    tick_pulse();
    expect_out("R4 first tick", 4'b1101);
    tick_pulse();
    expect_out("R4 R6 second tick, osc off", 4'b0000);

    // R10: more halt codes while halted
    @(negedge clk) stat = 3'b111;
    step(6);
    stat = 3'b011;
    step(6);
    expect_out("R10 halted ignores status", 4'b0000);

    // R7/R8: start with 011 held
    start_pulse();
    expect_out("R7 start resumes", 4'b1111);
    tick_pulse();
    tick_pulse();
    tick_pulse();
    step(8);
    expect_out("R8 held 011 no restop", 4'b1111);
    begin_stop();
    expect_out("R8 fresh 111-011 restops", 4'b1101);
    tick_pulse();
    tick_pulse();
    expect_out("R8 halted again", 4'b0000);

    // R6: gate mode
    @(negedge clk) mode_gate = 1'b1;
    expect_out("R6 gate mode osc up", 4'b0001);
    start_pulse();
    expect_out("R7 resume in gate mode", 4'b1111);
    begin_stop();
    tick_pulse();
    tick_pulse();
    expect_out("R6 gate mode halted", 4'b0001);
    @(negedge clk) mode_gate = 1'b0;
    start_pulse();
    expect_out("R7 resume", 4'b1111);

    // R2: glitch paths
    @(negedge clk) stat = 3'b111;
    step(6);
    stat = 3'b001;
    step(4);
    stat = 3'b011;
    step(8);
    expect_out("R2 111-001-011", 4'b1111);
    @(negedge clk) stat = 3'b110;
    step(6);
    stat = 3'b011;
    step(8);
    expect_out("R2 110-011", 4'b1111);

    // R7: start during drain
    begin_stop();
    expect_out("R7 drain entered", 4'b1101);
    tick_pulse();
    @(negedge clk) start = 1'b1;
    step(6);
    expect_out("R7 start mid drain", 4'b1111);
    tick_pulse();
    tick_pulse();
    expect_out("R7 ticks after start no effect", 4'b1111);
    @(negedge clk) start = 1'b0;
    step(4);

    // R5: widely spaced ticks
    begin_stop();
    tick_pulse();
    step(40);
    expect_out("R5 slow first tick", 4'b1101);
    step(40);
    tick_pulse();
    expect_out("R5 slow second tick", 4'b0000);

    start_pulse();
    expect_out("R7 final resume", 4'b1111);

    step(4);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule